// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block produces the ten gate enables of a phase-shifted full-bridge DC/DC converter from a single free-running period counter. There are four main switches in two legs, four auxiliary commutation switches (one pulse per leg transition) and two synchronous rectifiers. The only run-time control input is the phase shift between the legs. Dead times, the auxiliary pulse width, the rectifier guard time and a per-gate driver-delay compensation are fixed at build time as parameters.

Each leg runs on its own local time. That time is the master count minus the leg's reference point minus the compensation of the gate being generated, all taken modulo the period. The right-leg group is anchored at a rectifier turn-off point that lies the rectifier guard time ahead of the right leg's transition. The left leg gets the same guard delay as a virtual reference point, so the two legs stay exactly the phase word apart. With the defaults (100 MHz clock, 1000-cycle period) the switching frequency is 100 kHz.

Top module: `psfb_gate_seq`

## Requirements
- R1: After reset every gate is low and the sync pulse is low. The gate vector bits are: 0 left high, 1 left low, 2 right high, 3 right low, 4 left aux rising, 5 left aux falling, 6 right aux rising, 7 right aux falling, 8 positive-polarity rectifier, 9 negative-polarity rectifier.
- R2: While running, `sync_o` is a one-cycle pulse in the cycle where the period position c is 0, and it repeats exactly every PERIOD cycles.
- R3: While `enable_i` is low, all gates and sync are low from the next cycle on. After `enable_i` rises, gates stay low until the next period boundary, which is marked by sync.
- R4: With H = PERIOD/2 and local time t, each high switch is on for t in [DEAD, H) and each low switch for t in [H+DEAD, PERIOD). Each main switch therefore conducts for H-DEAD cycles per period. Left-leg local time is c - RECT_DEAD - comp.
- R5: Right-leg local time is c - (phi + RECT_DEAD) - comp. The right leg therefore lags the left leg by phi cycles, and the diagonal pairs (left high with right low, left low with right high) overlap for the power-transfer interval.
- R6: The phase word is taken only at the period boundary. A word above H is treated as H.
- R7: Each leg's rising-aux gate is on for local t in [0, AUX_ON) and its falling-aux gate for t in [H, H+AUX_ON). Each pulse therefore starts inside the leg dead time and lasts AUX_ON cycles.
- R8: The positive rectifier is on for (c - comp) in [RECT_DEAD+DEAD, phi) and the negative one for [RECT_DEAD+DEAD+H, phi+H). Both stay off when phi <= RECT_DEAD+DEAD. A rectifier is only on while the matching diagonal pair is on, and the two rectifiers are never on together.
- R9: Gate i is delayed by COMP[8*i +: 8] cycles on both edges relative to its uncompensated timing.
- R10: The high and low gates of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low asynchronous reset |
| enable_i | input | 1 | run request; low forces all gates off |
| phase_i | input | CW | leg phase shift in clock cycles |
| gate_o | output | 10 | gate enables, bit map per R1 |
| sync_o | output | 1 | period-start pulse |

## Verification
The assertions assume parameters in which DEAD and AUX_ON are below H and RECT_DEAD is small against H. The left auxiliary compensations must be at least the left low-side value, and the rectifier compensations must stay within RECT_DEAD of the main-switch values. Under those conditions the shifted windows still nest inside the dead times and polarity intervals. The stimulus runs only with the default constants, which meet these limits. Phase words are changed only from the bench at the falling clock edge, and they include values at 0, at the rectifier cut-off, at H and above H.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  localparam int N_GATE = 10;
  localparam int G_LHI  = 0;
  localparam int G_LLO  = 1;
  localparam int G_RHI  = 2;
  localparam int G_RLO  = 3;
  localparam int G_LAUP = 4;
  localparam int G_LADN = 5;
  localparam int G_RAUP = 6;
  localparam int G_RADN = 7;
  localparam int G_RPOS = 8;
  localparam int G_RNEG = 9;
  localparam int COMP_W = 8;
endpackage

// File: rtl/psfb_period_timer.sv
module psfb_period_timer #(
  parameter int PERIOD = 1000,
  parameter int CW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [CW-1:0] phase_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic [CW-1:0] phi_nxt_o,
  output logic          run_nxt_o,
  output logic          sync_o
);
  localparam int HALF = PERIOD / 2;
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt_q, phi_q;
  logic          run_q;
  logic          wrap;

  assign wrap      = (cnt_q == LAST_C);
  assign cnt_nxt_o = wrap ? '0 : cnt_q + 1'b1;
  assign run_nxt_o = enable_i & (run_q | wrap);
  assign phi_nxt_o = wrap ? ((phase_i > HALF_C) ? HALF_C : phase_i) : phi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      phi_q  <= '0;
      run_q  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt_o;
      phi_q  <= phi_nxt_o;
      run_q  <= run_nxt_o;
      sync_o <= run_nxt_o & (cnt_nxt_o == '0);
    end
  end

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o); // R2
endmodule

// File: rtl/psfb_event_window.sv
module psfb_event_window #(
  parameter int PERIOD   = 1000,
  parameter int CW       = 10,
  parameter int COMP_OFF = 0
) (
  input  logic [CW-1:0] t_now_i,
  input  logic [CW-1:0] ref_i,
  input  logic [CW:0]   start_i,
  input  logic [CW:0]   stop_i,
  output logic          hit_o
);
  localparam int DW = CW + 2;
  localparam logic [DW-1:0] P1 = DW'(PERIOD);
  localparam logic [DW-1:0] P2 = DW'(2 * PERIOD);
  localparam logic [DW-1:0] CO = DW'(COMP_OFF);

  logic [DW-1:0] raw, loc;

  always_comb begin
    raw = DW'(t_now_i) + P2 - DW'(ref_i) - CO;
    if (raw >= P2)      loc = raw - P2;
    else if (raw >= P1) loc = raw - P1;
    else                loc = raw;
    hit_o = (loc >= DW'(start_i)) && (loc < DW'(stop_i));
  end
endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
  import psfb_pkg::*;
#(
  parameter int PERIOD    = 1000,
  parameter int CW        = $clog2(PERIOD),
  parameter int DEAD      = 20,
  parameter int AUX_ON    = 40,
  parameter int RECT_DEAD = 10,
  parameter logic [N_GATE*COMP_W-1:0] COMP = {8'd5, 8'd5, 8'd5, 8'd5, 8'd4,
                                             8'd4, 8'd4, 8'd1, 8'd3, 8'd2}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [CW-1:0]     phase_i,
  output logic [N_GATE-1:0] gate_o,
  output logic              sync_o
);
  localparam int HALF = PERIOD / 2;
  localparam int W1   = CW + 1;

  logic [CW-1:0] cnt_n, phi_n, lref, rref;
  logic          run_n;
  logic [CW-1:0] ref_a   [N_GATE];
  logic [W1-1:0] start_a [N_GATE];
  logic [W1-1:0] stop_a  [N_GATE];
  logic [N_GATE-1:0] hit;

  psfb_period_timer #(.PERIOD(PERIOD), .CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .phase_i(phase_i),
    .cnt_nxt_o(cnt_n), .phi_nxt_o(phi_n), .run_nxt_o(run_n), .sync_o(sync_o)
  );

  assign lref = CW'(RECT_DEAD);
  assign rref = phi_n + CW'(RECT_DEAD);

  always_comb begin
    for (int i = 0; i < N_GATE; i++) begin
      ref_a[i]   = lref;
      start_a[i] = '0;
      stop_a[i]  = '0;
    end
    ref_a[G_RHI] = rref; ref_a[G_RLO] = rref;
    ref_a[G_RAUP] = rref; ref_a[G_RADN] = rref;
    ref_a[G_RPOS] = '0; ref_a[G_RNEG] = '0;
    for (int leg = 0; leg < 2; leg++) begin
      start_a[2*leg]       = W1'(DEAD);
      stop_a[2*leg]        = W1'(HALF);
      start_a[2*leg+1]     = W1'(HALF + DEAD);
      stop_a[2*leg+1]      = W1'(PERIOD);
      start_a[G_LAUP+2*leg]   = '0;
      stop_a[G_LAUP+2*leg]    = W1'(AUX_ON);
      start_a[G_LAUP+2*leg+1] = W1'(HALF);
      stop_a[G_LAUP+2*leg+1]  = W1'(HALF + AUX_ON);
    end
    start_a[G_RPOS] = W1'(RECT_DEAD + DEAD);
    stop_a[G_RPOS]  = {1'b0, phi_n};
    start_a[G_RNEG] = W1'(RECT_DEAD + DEAD + HALF);
    stop_a[G_RNEG]  = {1'b0, phi_n} + W1'(HALF);
  end

  for (genvar g = 0; g < N_GATE; g++) begin : g_win
    psfb_event_window #(
      .PERIOD(PERIOD), .CW(CW),
      .COMP_OFF(int'(COMP[g*COMP_W +: COMP_W]))
    ) win_i (
      .t_now_i(cnt_n), .ref_i(ref_a[g]), .start_i(start_a[g]),
      .stop_i(stop_a[g]), .hit_o(hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_o <= '0;
    else        gate_o <= run_n ? hit : '0;
  end

  AST_LEFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[G_LHI] && gate_o[G_LLO])); // R10
  AST_RIGHT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[G_RHI] && gate_o[G_RLO])); // R10
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (gate_o == '0) && !sync_o); // R3
  AST_RECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[G_RPOS] && gate_o[G_RNEG])); // R8
  AST_RECT_POS_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[G_RPOS] |-> gate_o[G_LHI] && gate_o[G_RLO]); // R8
  AST_RECT_NEG_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[G_RNEG] |-> gate_o[G_LLO] && gate_o[G_RHI]); // R8
  AST_AUX_IN_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o[G_LAUP]) || $rose(gate_o[G_LADN])) |->
      !gate_o[G_LHI] && !gate_o[G_LLO]); // R7
endmodule

// File: tb/psfb_gate_seq_tb.sv
module psfb_gate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 1000;
  localparam int H   = P / 2;
  localparam int DT  = 20;
  localparam int AON = 40;
  localparam int RDT = 10;
  localparam int CMP [10] = '{2, 3, 1, 4, 4, 4, 5, 5, 5, 5};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b0;
  logic [9:0] phase_i = '0;
  logic [9:0] gate_o;
  logic       sync_o;
  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psfb_gate_seq #(.PERIOD(P), .DEAD(DT), .AUX_ON(AON), .RECT_DEAD(RDT),
    .COMP({8'd5, 8'd5, 8'd5, 8'd5, 8'd4, 8'd4, 8'd4, 8'd1, 8'd3, 8'd2})) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .phase_i(phase_i),
    .gate_o(gate_o), .sync_o(sync_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_g(input int i, input int c, input int phi);
    int rf, s, e, t;
    int rl = RDT;
    int rr = phi + RDT;
    case (i)
      0: begin rf = rl; s = DT;           e = H;       end
      1: begin rf = rl; s = H + DT;       e = P;       end
      2: begin rf = rr; s = DT;           e = H;       end
      3: begin rf = rr; s = H + DT;       e = P;       end
      4: begin rf = rl; s = 0;            e = AON;     end
      5: begin rf = rl; s = H;            e = H + AON; end
      6: begin rf = rr; s = 0;            e = AON;     end
      7: begin rf = rr; s = H;            e = H + AON; end
      8: begin rf = 0;  s = RDT + DT;     e = phi;     end
      default: begin rf = 0; s = RDT + DT + H; e = phi + H; end
    endcase
    t = (c - rf - CMP[i] + 2 * P) % P;
    return (t >= s) && (t < e);
  endfunction

  task automatic wait_sync();
    @(negedge clk);
    while (!sync_o) @(negedge clk);
  endtask

  // Called at a falling edge where sync_o is high (c = 0).
  task automatic check_period(input int phi, input string tag);
    int mism [10];
    int hi_cnt = 0, aux_cnt = 0, first_lhi = -1, sync_extra = 0;
    string rq;
    for (int i = 0; i < 10; i++) mism[i] = 0;
    for (int c = 0; c < P; c++) begin
      for (int i = 0; i < 10; i++)
        if (gate_o[i] !== exp_g(i, c, phi)) mism[i]++;
      if (c > 0 && sync_o) sync_extra++;
      if (gate_o[0]) begin
        hi_cnt++;
        if (first_lhi < 0) first_lhi = c;
      end
      if (gate_o[4]) aux_cnt++;
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      rq = (i < 2) ? "R4" : (i < 4) ? "R5" : (i < 8) ? "R7" : "R8";
      chk(mism[i] == 0, $sformatf("%s %s gate%0d mismatched cycles", tag, rq, i), mism[i], 0);
    end
    chk(sync_o && sync_extra == 0, {tag, " R2 sync spacing"}, sync_extra, 0);
    chk(hi_cnt == H - DT, {tag, " R4 conduction"}, hi_cnt, H - DT);
    chk(aux_cnt == AON, {tag, " R7 aux width"}, aux_cnt, AON);
    chk(first_lhi == RDT + DT + CMP[0], {tag, " R9 compensated edge"}, first_lhi, RDT + DT + CMP[0]);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(gate_o == '0 && !sync_o, "R1 reset/idle outputs", int'(gate_o), 0);
    end
  endtask

  task automatic t_start(input int phi);
    int n = 0, leak = 0;
    phase_i = 10'(phi);
    repeat (137) @(negedge clk);
    enable_i = 1'b1;
    @(negedge clk);
    while (!sync_o && n <= P) begin
      if (gate_o != '0) leak++;
      n++;
      @(negedge clk);
    end
    chk(sync_o && n < P, "R3 start at boundary", n, P);
    chk(leak == 0, "R3 gates low before boundary", leak, 0);
  endtask

  task automatic t_phase(input int phi, input int exp_phi, input string tag);
    phase_i = 10'(phi);
    wait_sync();
    check_period(exp_phi, tag);
  endtask

  task automatic t_midchange(input int old_phi, input int new_phi);
    wait_sync();
    phase_i = 10'(new_phi);
    check_period(old_phi, "R6 held mid-period");
    check_period(new_phi, "R6 loaded at wrap");
  endtask

  task automatic t_disable();
    int on = 0;
    repeat (300) @(negedge clk);
    enable_i = 1'b0;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      if (gate_o != '0 || sync_o) on++;
    end
    chk(on == 0, "R3 disabled holds off", on, 0);
    enable_i = 1'b1;
    wait_sync();
    check_period(250, "R3 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_start(200);
    check_period(200, "first");
    t_phase(0, 0, "phi0");
    t_phase(RDT + DT, RDT + DT, "R8 empty rect");
    t_phase(H, H, "phi max");
    t_phase(H + 200, H, "R6 clamp");
    phase_i = 10'd150;
    wait_sync();
    check_period(150, "phi150");
    t_midchange(150, 330);
    phase_i = 10'd250;
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    fin = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule